// File: doc/BRIEF.md
# USB Device Control Register with Packet Lockout

This block is the control and status register that sits between a CPU bus and a USB serial interface engine. The CPU sees two 8-bit locations: a control register and an event-status register. The control register holds four state bits:

- **Packet lockout:** blocks all packet transmission and reception.
- **Low-power suspend:** stops the engine clock and parks the transceiver.
- **Remote-wakeup resume:** requests resume signalling.
- **Buffer-pointer reset:** a plain software-owned bit.

The packet lockout bit is owned jointly. The engine sets it whenever a SETUP token arrives, so that software can process the request before more traffic flows. The CPU can only clear it, which releases the traffic again.

Software must hold the resume bit for 10 ms and then clear it to make a valid remote wakeup. It should set suspend only after an idle event has been flagged, and clear suspend after an activity event. The engine reports idle and activity through event pulses. These pulses set sticky flags, which software clears by writing ones. If software writes suspend = 1 while no idle flag is pending, the write still takes effect, and a sticky protocol-error flag records the misuse. An interrupt output is the OR of the three sticky flags.

Top module: `usbctl_top`

## Requirements
- R1: After reset, both registers read 0x00, eng_clk_en is 1, and pkt_hold, xcvr_idle, resume_req, ptr_rst and irq are 0.
- R2: A setup_pulse sets the packet lockout bit (control bit 4) at the next clock edge. pkt_hold equals that bit.
- R3: A CPU write to the control register (cpu_addr = 0) that has bit 4 = 1 leaves the lockout bit unchanged. A write with bit 4 = 0 clears it.
- R4: When setup_pulse and a CPU write with bit 4 = 0 occur in the same cycle, the lockout bit is 1 after the edge.
- R5: Control bit 1 is the suspend bit. While it is 1, eng_clk_en is 0 and xcvr_idle is 1. While it is 0, eng_clk_en is 1 and xcvr_idle is 0.
- R6: Control bit 2 drives resume_req and control bit 6 drives ptr_rst. Each keeps the last value written until the next control write.
- R7: Control bits 7, 5, 3 and 0 always read 0, whatever value is written to them.
- R8: idle_evt sets status bit 0 (cpu_addr = 1) and act_evt sets status bit 1. Both flags stay set until the CPU writes 1 to that bit. irq is the OR of status bits 0, 1 and 2. Status bits 7..3 read 0.
- R9: When an event pulse and a write-1-to-clear of the same flag occur in the same cycle, the flag is 1 after the edge.
- R10: A control write with bit 1 = 1 sets status bit 2 (protocol error) if status bit 0 was 0 before that edge. The error bit is sticky and is cleared by writing 1 to status bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 1 | Register select: 0 = control, 1 = event status |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data for the selected register (combinational) |
| setup_pulse | input | 1 | Engine: SETUP token received |
| idle_evt | input | 1 | Engine: bus idle detected |
| act_evt | input | 1 | Engine: bus activity detected |
| eng_clk_en | output | 1 | Clock enable to the engine, low in suspend |
| pkt_hold | output | 1 | Holds off packet transmission and reception |
| xcvr_idle | output | 1 | Forces the transceiver outputs idle |
| resume_req | output | 1 | Request for resume signalling |
| ptr_rst | output | 1 | Resets the buffer pointers to the even buffers |
| irq | output | 1 | Interrupt, OR of the sticky flags |

## Verification
The engine and the CPU share two pieces of state, so their actions can fall in the same cycle:

- **Lockout bit:** a setup_pulse can arrive in the same cycle as a CPU clear of the lockout bit.
- **Event flags:** an idle or activity pulse can arrive in the same cycle as a write-1-to-clear of that flag.

Directed cycles put both actions on the same edge, and a long pseudo-random phase makes many more such collisions. The bench judges them against a behavioural model, in which the hardware set always overrides the software clear. The model is compared with every output and the read data on every cycle. The suspend write that lands in the same cycle as an idle pulse is also exercised: it must raise the error, because only the flag value before the edge counts.

// File: rtl/usbctl_pkg.sv
package usbctl_pkg;
  localparam int DW = 8;
  localparam int AW = 1;
  // control register bit positions
  localparam int CB_PTRRST = 6;
  localparam int CB_PKTDIS = 4;
  localparam int CB_RESUME = 2;
  localparam int CB_SUSP   = 1;
  // status register bit positions
  localparam int SB_IDLE = 0;
  localparam int SB_ACT  = 1;
  localparam int SB_PERR = 2;
  localparam int NEV     = 2;
  localparam logic [AW-1:0] A_CTRL = '0;
  localparam logic [AW-1:0] A_STAT = 1;

  // sticky bit update: hardware set dominates software clear
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // bits of the control register directly written by the CPU
  function automatic logic [DW-1:0] ctrl_rw_mask();
    logic [DW-1:0] m;
    m = '0;
    m[CB_PTRRST] = 1'b1;
    m[CB_RESUME] = 1'b1;
    m[CB_SUSP]   = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/usbctl_ctrl_bits.sv
module usbctl_ctrl_bits
  import usbctl_pkg::*;
#(
  parameter int DATA_W = DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              setup_pulse,
  output logic [DATA_W-1:0] ctrl_q
);
  localparam logic [DATA_W-1:0] RW_MASK = DATA_W'(ctrl_rw_mask());

  logic [DATA_W-1:0] plain_q;
  logic              pkt_dis_q;
  logic              cpu_clr_pd;   // CPU asks to release the lockout
  logic              cpu_try_pd;   // CPU tries to set the lockout (ignored)

  assign cpu_clr_pd = wr_ctrl & ~wdata[CB_PKTDIS];
  assign cpu_try_pd = wr_ctrl &  wdata[CB_PKTDIS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plain_q   <= '0;
      pkt_dis_q <= 1'b0;
    end else begin
      pkt_dis_q <= sticky_next(pkt_dis_q, setup_pulse, cpu_clr_pd);
      if (wr_ctrl) plain_q <= wdata & RW_MASK;
    end
  end

  always_comb begin
    ctrl_q = plain_q;
    ctrl_q[CB_PKTDIS] = pkt_dis_q;
  end

  // R2 R4
  setup_sets_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_pulse |=> pkt_dis_q);
  // R3
  cpu_cannot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_try_pd && !setup_pulse && !pkt_dis_q) |=> !pkt_dis_q);
  // R3
  cpu_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clr_pd && !setup_pulse) |=> !pkt_dis_q);
  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q[7] == 1'b0 && ctrl_q[5] == 1'b0 && ctrl_q[3] == 1'b0 && ctrl_q[0] == 1'b0));
endmodule

// File: rtl/usbctl_evt_flags.sv
module usbctl_evt_flags
  import usbctl_pkg::*;
#(
  parameter int N_EV = NEV
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] evt,
  input  logic [N_EV-1:0] w1c,
  input  logic            susp_set_wr,
  input  logic            perr_clr,
  output logic [N_EV-1:0] flags,
  output logic            perr
);
  logic perr_raise;   // suspend requested with no idle pending
  assign perr_raise = susp_set_wr & ~flags[SB_IDLE];

  for (genvar i = 0; i < N_EV; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= sticky_next(flags[i], evt[i], w1c[i]);
    end
    // R8
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags[i]);
    // R8
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c[i] && !evt[i]) |=> !flags[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) perr <= 1'b0;
    else        perr <= sticky_next(perr, perr_raise, perr_clr);
  end

  // R10
  perr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_set_wr && !flags[SB_IDLE]) |=> perr);
  // R10
  perr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!perr && !susp_set_wr) |=> !perr);
endmodule

// File: rtl/usbctl_top.sv
module usbctl_top
  import usbctl_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              setup_pulse,
  input  logic              idle_evt,
  input  logic              act_evt,
  output logic              eng_clk_en,
  output logic              pkt_hold,
  output logic              xcvr_idle,
  output logic              resume_req,
  output logic              ptr_rst,
  output logic              irq
);
  logic              wr_ctrl, wr_stat;
  logic [DATA_W-1:0] ctrl_q;
  logic [NEV-1:0]    ev_vec, w1c_vec, flags;
  logic              perr, susp_set_wr;
  logic [DATA_W-1:0] stat_q;

  assign wr_ctrl     = cpu_we && (cpu_addr == ADDR_W'(A_CTRL));
  assign wr_stat     = cpu_we && (cpu_addr == ADDR_W'(A_STAT));
  assign susp_set_wr = wr_ctrl & cpu_wdata[CB_SUSP];

  assign ev_vec[SB_IDLE]  = idle_evt;
  assign ev_vec[SB_ACT]   = act_evt;
  assign w1c_vec = wr_stat ? cpu_wdata[NEV-1:0] : '0;

  usbctl_ctrl_bits #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(cpu_wdata),
    .setup_pulse(setup_pulse), .ctrl_q(ctrl_q)
  );

  usbctl_evt_flags #(.N_EV(NEV)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(ev_vec), .w1c(w1c_vec),
    .susp_set_wr(susp_set_wr), .perr_clr(wr_stat & cpu_wdata[SB_PERR]),
    .flags(flags), .perr(perr)
  );

  always_comb begin
    stat_q = '0;
    stat_q[NEV-1:0] = flags;
    stat_q[SB_PERR] = perr;
  end

  assign cpu_rdata  = (cpu_addr == ADDR_W'(A_CTRL)) ? ctrl_q : stat_q;
  assign pkt_hold   = ctrl_q[CB_PKTDIS];
  assign eng_clk_en = ~ctrl_q[CB_SUSP];
  assign xcvr_idle  = ctrl_q[CB_SUSP];
  assign resume_req = ctrl_q[CB_RESUME];
  assign ptr_rst    = ctrl_q[CB_PTRRST];
  assign irq        = |flags | perr;

  // R5
  suspend_gates_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_set_wr |=> (!eng_clk_en && xcvr_idle));
  // R5
  wake_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !cpu_wdata[CB_SUSP]) |=> (eng_clk_en && !xcvr_idle));
  // R6
  resume_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(resume_req) && $stable(ptr_rst));
  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !idle_evt && !act_evt && !susp_set_wr) |=> !irq);
endmodule

// File: tb/tb_usbctl_top.sv
module tb_usbctl_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_we = 1'b0;
  logic [0:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       setup_pulse = 1'b0, idle_evt = 1'b0, act_evt = 1'b0;
  logic       eng_clk_en, pkt_hold, xcvr_idle, resume_req, ptr_rst, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  bit m_pd, m_su, m_rs, m_pr, m_if, m_af, m_pe;

  always #10 clk = ~clk;

  usbctl_top dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .setup_pulse(setup_pulse),
    .idle_evt(idle_evt), .act_evt(act_evt), .eng_clk_en(eng_clk_en),
    .pkt_hold(pkt_hold), .xcvr_idle(xcvr_idle), .resume_req(resume_req),
    .ptr_rst(ptr_rst), .irq(irq)
  );

  function automatic logic [13:0] expected(input bit a);
    logic [7:0] rd;
    if (a == 1'b0) rd = {1'b0, m_pr, 1'b0, m_pd, 1'b0, m_rs, m_su, 1'b0};
    else           rd = {5'b0, m_pe, m_af, m_if};
    return {rd, !m_su, m_pd, m_su, m_rs, m_pr, (m_if || m_af || m_pe)};
  endfunction

  task automatic compare(input string tag);
    logic [13:0] got, exp;
    got = {cpu_rdata, eng_clk_en, pkt_hold, xcvr_idle, resume_req, ptr_rst, irq};
    exp = expected(cpu_addr[0]);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (addr %0d)", tag, got, exp, cpu_addr);
    end
  endtask

  // one clock: drive at negedge, compare, then advance the model at posedge
  task automatic cyc(input bit we, input bit a, input logic [7:0] wd,
                     input bit su, input bit id, input bit ac, input string tag);
    bit wc, ws;
    @(negedge clk);
    cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    setup_pulse = su; idle_evt = id; act_evt = ac;
    #2;
    compare(tag);
    @(posedge clk);
    wc = we && !a;
    ws = we && a;
    if (wc && wd[1] && !m_if) m_pe = 1;
    else if (ws && wd[2])     m_pe = 0;
    if (su)                   m_pd = 1;
    else if (wc && !wd[4])    m_pd = 0;
    if (wc) begin m_su = wd[1]; m_rs = wd[2]; m_pr = wd[6]; end
    if (id)                   m_if = 1;
    else if (ws && wd[0])     m_if = 0;
    if (ac)                   m_af = 1;
    else if (ws && wd[1])     m_af = 0;
  endtask

  task automatic idle_cycles(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, i[0], 8'h00, 0, 0, 0, tag);
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    {m_pd, m_su, m_rs, m_pr, m_if, m_af, m_pe} = '0;
    repeat (3) @(negedge clk);
    #2; compare("R1 reset ctrl");
    cpu_addr = 1'b1; #1; compare("R1 reset status");
    @(negedge clk); rst_n = 1'b1;
    idle_cycles(2, "R1");

    // R2: setup sets lockout
    cyc(0, 0, 0, 1, 0, 0, "R2");
    idle_cycles(3, "R2 hold");
    // R3: CPU write 1 ignored, write 0 clears
    cyc(1, 0, 8'h10, 0, 0, 0, "R3 write one");
    idle_cycles(2, "R3");
    cyc(1, 0, 8'h00, 0, 0, 0, "R3 clear");
    cyc(1, 0, 8'h10, 0, 0, 0, "R3 set attempt");
    idle_cycles(2, "R3 no set");
    // R4: collision of setup and clear
    cyc(1, 0, 8'h00, 1, 0, 0, "R4 collide");
    idle_cycles(2, "R4 result");
    cyc(1, 0, 8'h00, 0, 0, 0, "R4 release");
    // R5, R10: suspend after idle (no error)
    cyc(0, 1, 0, 0, 1, 0, "R8 idle evt");
    cyc(1, 0, 8'h02, 0, 0, 0, "R5 suspend ok");
    idle_cycles(3, "R5 suspended");
    cyc(0, 1, 0, 0, 0, 1, "R8 act evt");
    cyc(1, 0, 8'h00, 0, 0, 0, "R5 wake");
    cyc(1, 1, 8'h03, 0, 0, 0, "R8 w1c");
    idle_cycles(2, "R8 cleared");
    // R10: suspend with no idle flag
    cyc(1, 0, 8'h02, 0, 0, 0, "R10 early suspend");
    idle_cycles(2, "R10 perr");
    cyc(1, 1, 8'h04, 0, 0, 0, "R10 perr clear");
    cyc(1, 0, 8'h02, 0, 1, 0, "R10 same-cycle idle");
    idle_cycles(2, "R10 perr again");
    cyc(1, 1, 8'h07, 0, 0, 0, "R10 clear all");
    cyc(1, 0, 8'h00, 0, 0, 0, "R5");
    // R6: resume and pointer reset hold
    cyc(1, 0, 8'h44, 0, 0, 0, "R6 set");
    idle_cycles(4, "R6 held");
    cyc(1, 0, 8'h00, 0, 0, 0, "R6 clear");
    // R7: reserved bits
    cyc(1, 0, 8'hA9, 0, 0, 0, "R7 reserved");
    idle_cycles(2, "R7");
    cyc(1, 0, 8'hFF, 0, 0, 0, "R7 all ones");
    idle_cycles(2, "R7");
    // R9: event and w1c in the same cycle
    cyc(0, 1, 0, 0, 1, 1, "R9 set both");
    cyc(1, 1, 8'h03, 0, 1, 0, "R9 idle collide");
    idle_cycles(2, "R9 idle kept");
    cyc(1, 1, 8'h03, 0, 0, 1, "R9 act collide");
    idle_cycles(2, "R9 act kept");
    cyc(1, 1, 8'hFF, 0, 0, 0, "R8 clear all");
    idle_cycles(2, "R8 status reserved zero");

    // mixed pseudo-random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom;
      cyc(r[0] & r[1], r[2], 8'($urandom), r[3] & r[4] & r[5],
          r[6] & r[7], r[8] & r[9] & r[10], "mixed");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule